// File: doc/BRIEF.md
# Bus-Match Debug Trigger Unit

This block observes every cycle of a CPU bus (address, data, read, write and opcode-fetch strobes) together with two status lines from the core that report whether the most recently fetched opcode was executed or flushed. Two programmable comparators, A and B, feed a condition selected by a 4-bit mode field. When the selected condition is met, the unit raises a one-cycle trigger pulse and steers a store-enable strobe toward an external trace buffer. That buffer is not part of this block.

An 8-bit control word picks the condition, whether comparator hits must be confirmed by opcode execution, and whether the trigger opens the capture window or closes a continuously running one. A separate arm bit starts a run. When a run completes, the unit raises a sticky capture-done flag and disarms itself. Software re-arms it for the next run. Every output is registered, so a bus cycle's effect appears on the outputs on the following clock edge.

Top module: `dbt_trigger_unit`

## Requirements
- R1: The control word resets to 0x00. Bit 7 is the execution-qualification select, bit 6 is the start-on-trigger select, and bits 3:0 are the mode. Bits 5:4 always read 0, whatever is written to them.
- R2: A control write takes effect only while the unit is disarmed. A write made while armed leaves the readback unchanged.
- R3: An access is any cycle with the read, write or fetch strobe high. Mode 0 triggers on an access whose address equals A. Mode 1 triggers on an access whose address equals A or equals B.
- R4: Modes 2 and 4 need an A hit in an earlier cycle than the B hit. The remembered A hit is discarded whenever the unit is disarmed.
- R5: Mode 5 triggers on an access at address A whose data equals the low data-width bits of B. Mode 6 triggers on an access at address A whose data differs from those bits.
- R6: Mode 7 triggers when A ≤ address ≤ B. Mode 8 triggers when the address is below A or above B.
- R7: Mode values 9 to 15 never produce a trigger pulse or a trigger-caused store.
- R8: With bit 7 set in modes 0 to 2, only fetch cycles can match. A match is held pending and counts only in a later cycle that reports execution. A flush drops the pending match without a trigger. In all other modes bit 7 has no effect.
- R9: With bit 6 set (start-on-trigger), storing begins with the triggering access, if that cycle is an access, and continues on every later access. After DEPTH stores the unit sets done and disarms. Only the first trigger of a run pulses.
- R10: With bit 6 clear, every access is stored while the unit is armed. The trigger, whose own access is also stored, sets done and disarms in the same edge.
- R11: Modes 3 and 4 ignore bit 6. Each qualifying B access gives exactly one trigger pulse and one store, and the store carries that access's address and data. After DEPTH such stores the unit sets done and disarms.
- R12: Outputs change one edge after the cycle that causes them. Done stays set while the unit is disarmed. Writing the arm bit to 1 clears done and restarts the run state. Nothing is stored or triggered while the unit is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 8 | Control word write value |
| cfg_rd_data | output | 8 | Control word readback |
| arm_wr_en | input | 1 | Arm bit write strobe |
| arm_wr_val | input | 1 | Arm bit value to write |
| cmp_a_addr | input | AW | Comparator A value |
| cmp_b_addr | input | AW | Comparator B value (its low DW bits are the data reference) |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_fetch | input | 1 | Opcode fetch strobe |
| core_exec | input | 1 | The pending fetched opcode was executed |
| core_flush | input | 1 | The pending fetched opcode was discarded |
| trig_pulse | output | 1 | One-cycle trigger event |
| store_en | output | 1 | Trace buffer write strobe |
| store_addr | output | AW | Address to store |
| store_data | output | DW | Data to store |
| capture_done | output | 1 | Sticky run-complete flag |
| armed | output | 1 | Arm bit state |

## Verification
Assertions run on every cycle and check several invariants. The reserved control bits stay zero. The control word cannot change in the cycle after the unit is armed. Stores and trigger pulses occur only when the previous cycle was armed, and no trigger follows an undefined mode. Done always coincides with disarm. The store count never exceeds the depth. In event-only modes each trigger is paired with a store. A flush clears any pending tagged match. Only the bench scenarios can show which access patterns trigger. These include A-before-B ordering, inclusive range edges, data equal and not-equal, and a flush followed by a re-fetch and execution. They also show the exact number of stores that bounds a run, and that done persists until the next arm.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  localparam logic [3:0] MODE_A_ONLY      = 4'd0;
  localparam logic [3:0] MODE_A_OR_B      = 4'd1;
  localparam logic [3:0] MODE_A_THEN_B    = 4'd2;
  localparam logic [3:0] MODE_EV_B        = 4'd3;
  localparam logic [3:0] MODE_A_THEN_EV_B = 4'd4;
  localparam logic [3:0] MODE_DATA_EQ     = 4'd5;
  localparam logic [3:0] MODE_DATA_NE     = 4'd6;
  localparam logic [3:0] MODE_IN_RANGE    = 4'd7;
  localparam logic [3:0] MODE_OUT_RANGE   = 4'd8;

  localparam int         CTRL_W     = 8;
  localparam logic [7:0] CTRL_WMASK = 8'hCF;

  typedef struct packed {
    logic       exec_qual;
    logic       start_on_trig;
    logic [1:0] zero_bits;
    logic [3:0] mode;
  } ctrl_t;

  typedef struct packed {
    logic a;
    logic b;
    logic deq;
    logic dne;
    logic inr;
    logic outr;
  } hit_t;

  function automatic logic mode_event_only(input logic [3:0] m);
    return (m == MODE_EV_B) || (m == MODE_A_THEN_EV_B);
  endfunction

  function automatic logic mode_tag_capable(input logic [3:0] m);
    return m <= MODE_A_THEN_B;
  endfunction

  function automatic logic mode_defined(input logic [3:0] m);
    return m <= MODE_OUT_RANGE;
  endfunction

endpackage

// File: rtl/dbt_ctrl_reg.sv
module dbt_ctrl_reg
  import dbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              armed,
  output ctrl_t             ctrl,
  output logic [CTRL_W-1:0] rd_data
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && !armed) begin
      ctrl_q <= ctrl_t'(wr_data & CTRL_WMASK);
    end
  end

  assign ctrl    = ctrl_q;
  assign rd_data = ctrl_q;

  // R1: unimplemented bits never hold a one
  p_zero_bits_r1: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.zero_bits == 2'b00);

  // R2: configuration is frozen while armed
  p_locked_when_armed_r2: assert property (@(posedge clk) disable iff (rst)
    armed |=> $stable(ctrl_q));

endmodule

// File: rtl/dbt_match.sv
module dbt_match
  import dbt_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          acc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] cmp_a,
  input  logic [AW-1:0] cmp_b,
  output hit_t          hits
);

  logic [DW-1:0] data_ref;
  logic          at_a;
  logic          at_b;
  logic          ge_a;
  logic          le_b;

  generate
    if (DW <= AW) begin : g_ref_slice
      assign data_ref = cmp_b[DW-1:0];
    end else begin : g_ref_extend
      assign data_ref = {{(DW-AW){1'b0}}, cmp_b};
    end
  endgenerate

  assign at_a = (addr == cmp_a);
  assign at_b = (addr == cmp_b);
  assign ge_a = (addr >= cmp_a);
  assign le_b = (addr <= cmp_b);

  always_comb begin
    hits.a    = acc && at_a;
    hits.b    = acc && at_b;
    hits.deq  = acc && at_a && (data == data_ref);
    hits.dne  = acc && at_a && (data != data_ref);
    hits.inr  = acc && ge_a && le_b;
    hits.outr = acc && (!ge_a || !le_b);
  end

endmodule

// File: rtl/dbt_tag.sv
module dbt_tag
  import dbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       armed,
  input  logic       exec_qual,
  input  logic [3:0] mode,
  input  logic       fetch,
  input  logic       exec,
  input  logic       flush,
  input  logic       raw_a,
  input  logic       raw_b,
  output logic       q_a,
  output logic       q_b
);

  logic tag_en;
  logic pend_a_q;
  logic pend_b_q;

  assign tag_en = exec_qual && mode_tag_capable(mode);

  always_ff @(posedge clk) begin
    if (rst || !armed || !tag_en) begin
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else if (fetch && (raw_a || raw_b)) begin
      pend_a_q <= raw_a;
      pend_b_q <= raw_b;
    end else if (exec || flush) begin
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end
  end

  always_comb begin
    if (tag_en) begin
      q_a = pend_a_q && exec;
      q_b = pend_b_q && exec;
    end else begin
      q_a = raw_a;
      q_b = raw_b;
    end
  end

  // R8: a flush without a new fetch leaves nothing pending to fire later
  p_flush_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (tag_en && flush && !fetch) |=> !(pend_a_q || pend_b_q));

  // R8: in tag mode, qualified hits only appear with an execution report
  p_hit_needs_exec_r8: assert property (@(posedge clk) disable iff (rst)
    (tag_en && (q_a || q_b)) |-> exec);

endmodule

// File: rtl/dbt_capture.sv
module dbt_capture
  import dbt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    mode,
  input  logic          start_on_trig,
  input  logic          q_a,
  input  logic          q_b,
  input  logic          hit_deq,
  input  logic          hit_dne,
  input  logic          hit_inr,
  input  logic          hit_outr,
  input  logic          acc,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          arm_wr_en,
  input  logic          arm_wr_val,
  output logic          trig_o,
  output logic          store_o,
  output logic [AW-1:0] store_addr_o,
  output logic [DW-1:0] store_data_o,
  output logic          done_o,
  output logic          armed_o
);

  localparam int            CW   = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic          armed_q, done_q, aseen_q, started_q;
  logic [CW-1:0] cnt_q;
  logic          trig_q, store_q;
  logic [AW-1:0] saddr_q;
  logic [DW-1:0] sdata_q;

  logic          cond, evt, evonly, begin_eff, mode_ok;
  logic          trig_c, store_c, finish_c;
  logic          armed_n, done_n, aseen_n, started_n;
  logic [CW-1:0] cnt_n;

  assign evonly    = mode_event_only(mode);
  assign begin_eff = start_on_trig || evonly;
  assign mode_ok   = mode_defined(mode);

  always_comb begin
    case (mode)
      MODE_A_ONLY:      cond = q_a;
      MODE_A_OR_B:      cond = q_a || q_b;
      MODE_A_THEN_B:    cond = aseen_q && q_b;
      MODE_EV_B:        cond = q_b;
      MODE_A_THEN_EV_B: cond = aseen_q && q_b;
      MODE_DATA_EQ:     cond = hit_deq;
      MODE_DATA_NE:     cond = hit_dne;
      MODE_IN_RANGE:    cond = hit_inr;
      MODE_OUT_RANGE:   cond = hit_outr;
      default:          cond = 1'b0;
    endcase
    evt = armed_q && cond;
  end

  always_comb begin
    trig_c   = 1'b0;
    store_c  = 1'b0;
    finish_c = 1'b0;
    if (armed_q) begin
      if (evonly) begin
        trig_c  = evt;
        store_c = evt;
      end else if (begin_eff) begin
        trig_c  = evt && !started_q;
        store_c = acc && (started_q || evt);
      end else begin
        trig_c  = evt;
        store_c = acc;
      end
      if (begin_eff) begin
        finish_c = store_c && (cnt_q == LAST);
      end else begin
        finish_c = evt;
      end
    end
  end

  always_comb begin
    armed_n   = armed_q;
    done_n    = done_q;
    cnt_n     = cnt_q;
    started_n = started_q;
    aseen_n   = armed_q && (aseen_q || q_a);
    if (begin_eff && store_c) begin
      cnt_n = cnt_q + 1'b1;
    end
    if (begin_eff && evt) begin
      started_n = 1'b1;
    end
    if (finish_c) begin
      armed_n = 1'b0;
      done_n  = 1'b1;
    end
    if (arm_wr_en) begin
      armed_n = arm_wr_val;
      aseen_n = 1'b0;
      if (arm_wr_val) begin
        done_n    = 1'b0;
        cnt_n     = '0;
        started_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      done_q    <= 1'b0;
      aseen_q   <= 1'b0;
      started_q <= 1'b0;
      cnt_q     <= '0;
      trig_q    <= 1'b0;
      store_q   <= 1'b0;
      saddr_q   <= '0;
      sdata_q   <= '0;
    end else begin
      armed_q   <= armed_n;
      done_q    <= done_n;
      aseen_q   <= aseen_n;
      started_q <= started_n;
      cnt_q     <= cnt_n;
      trig_q    <= trig_c;
      store_q   <= store_c;
      if (store_c) begin
        saddr_q <= bus_addr;
        sdata_q <= bus_data;
      end
    end
  end

  assign trig_o       = trig_q;
  assign store_o      = store_q;
  assign store_addr_o = saddr_q;
  assign store_data_o = sdata_q;
  assign done_o       = done_q;
  assign armed_o      = armed_q;

  // R12: stores only follow an armed cycle
  p_store_when_armed_r12: assert property (@(posedge clk) disable iff (rst)
    store_q |-> $past(armed_q));

  // R12: completion always leaves the unit disarmed
  p_done_disarms_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> !armed_q);

  // R7: no trigger follows a cycle with an undefined mode
  p_no_undef_trig_r7: assert property (@(posedge clk) disable iff (rst)
    trig_q |-> $past(mode_ok));

  // R9: run length never exceeds the buffer depth
  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  // R11: every event-only trigger carries its store
  p_event_store_pair_r11: assert property (@(posedge clk) disable iff (rst)
    (trig_q && $past(evonly)) |-> store_q);

endmodule

// File: rtl/dbt_trigger_unit.sv
module dbt_trigger_unit
  import dbt_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr_en,
  input  logic [7:0]    cfg_wr_data,
  output logic [7:0]    cfg_rd_data,
  input  logic          arm_wr_en,
  input  logic          arm_wr_val,
  input  logic [AW-1:0] cmp_a_addr,
  input  logic [AW-1:0] cmp_b_addr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_fetch,
  input  logic          core_exec,
  input  logic          core_flush,
  output logic          trig_pulse,
  output logic          store_en,
  output logic [AW-1:0] store_addr,
  output logic [DW-1:0] store_data,
  output logic          capture_done,
  output logic          armed
);

  ctrl_t ctrl;
  hit_t  hits;
  logic  acc;
  logic  q_a, q_b;
  logic  armed_int;

  assign acc   = bus_rd || bus_wr || bus_fetch;
  assign armed = armed_int;

  dbt_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .armed   (armed_int),
    .ctrl    (ctrl),
    .rd_data (cfg_rd_data)
  );

  dbt_match #(.AW(AW), .DW(DW)) u_match (
    .acc   (acc),
    .addr  (bus_addr),
    .data  (bus_data),
    .cmp_a (cmp_a_addr),
    .cmp_b (cmp_b_addr),
    .hits  (hits)
  );

  dbt_tag u_tag (
    .clk       (clk),
    .rst       (rst),
    .armed     (armed_int),
    .exec_qual (ctrl.exec_qual),
    .mode      (ctrl.mode),
    .fetch     (bus_fetch),
    .exec      (core_exec),
    .flush     (core_flush),
    .raw_a     (hits.a),
    .raw_b     (hits.b),
    .q_a       (q_a),
    .q_b       (q_b)
  );

  dbt_capture #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_capture (
    .clk           (clk),
    .rst           (rst),
    .mode          (ctrl.mode),
    .start_on_trig (ctrl.start_on_trig),
    .q_a           (q_a),
    .q_b           (q_b),
    .hit_deq       (hits.deq),
    .hit_dne       (hits.dne),
    .hit_inr       (hits.inr),
    .hit_outr      (hits.outr),
    .acc           (acc),
    .bus_addr      (bus_addr),
    .bus_data      (bus_data),
    .arm_wr_en     (arm_wr_en),
    .arm_wr_val    (arm_wr_val),
    .trig_o        (trig_pulse),
    .store_o       (store_en),
    .store_addr_o  (store_addr),
    .store_data_o  (store_data),
    .done_o        (capture_done),
    .armed_o       (armed_int)
  );

endmodule

// File: tb/dbt_trigger_unit_tb.sv
module dbt_trigger_unit_tb;

  localparam int AW    = 16;
  localparam int DW    = 8;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_en = 1'b0;
  logic [7:0]    cfg_wr_data = '0;
  logic [7:0]    cfg_rd_data;
  logic          arm_wr_en = 1'b0, arm_wr_val = 1'b0;
  logic [AW-1:0] cmp_a_addr = 16'h0010, cmp_b_addr = 16'h0040;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic          bus_rd = 0, bus_wr = 0, bus_fetch = 0, core_exec = 0, core_flush = 0;
  logic          trig_pulse, store_en, capture_done, armed;
  logic [AW-1:0] store_addr;
  logic [DW-1:0] store_data;

  always #5 clk = ~clk;

  dbt_trigger_unit #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .arm_wr_en(arm_wr_en), .arm_wr_val(arm_wr_val),
    .cmp_a_addr(cmp_a_addr), .cmp_b_addr(cmp_b_addr), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_fetch(bus_fetch),
    .core_exec(core_exec), .core_flush(core_flush), .trig_pulse(trig_pulse),
    .store_en(store_en), .store_addr(store_addr), .store_data(store_data),
    .capture_done(capture_done), .armed(armed)
  );

  int    n_chk = 0, n_fail = 0, n_trig = 0, n_store = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0]    m_cfg = '0;
  logic          m_armed = 0, m_done = 0, m_aseen = 0, m_started = 0, m_pa = 0, m_pb = 0;
  int            m_cnt = 0;
  logic          e_trig = 0, e_store = 0;
  logic [AW-1:0] e_saddr = '0;
  logic [DW-1:0] e_sdata = '0;

  always @(posedge clk) begin : ref_model
    logic       acc, tagm, qa, qb, ev, evonly, beg, fin, arm0;
    logic [3:0] md;
    if (rst) begin
      m_cfg = '0; m_armed = 0; m_done = 0; m_aseen = 0; m_started = 0;
      m_pa = 0; m_pb = 0; m_cnt = 0; e_trig = 0; e_store = 0;
    end else begin
      arm0 = m_armed;
      md   = m_cfg[3:0];
      acc  = bus_rd | bus_wr | bus_fetch;
      tagm = m_cfg[7] && (md <= 4'd2);
      if (tagm) begin
        qa = m_pa && core_exec;
        qb = m_pb && core_exec;
      end else begin
        qa = acc && (bus_addr == cmp_a_addr);
        qb = acc && (bus_addr == cmp_b_addr);
      end
      case (md)
        4'd0: ev = qa;
        4'd1: ev = qa || qb;
        4'd2, 4'd4: ev = m_aseen && qb;
        4'd3: ev = qb;
        4'd5: ev = acc && bus_addr == cmp_a_addr && bus_data == cmp_b_addr[7:0];
        4'd6: ev = acc && bus_addr == cmp_a_addr && bus_data != cmp_b_addr[7:0];
        4'd7: ev = acc && bus_addr >= cmp_a_addr && bus_addr <= cmp_b_addr;
        4'd8: ev = acc && (bus_addr < cmp_a_addr || bus_addr > cmp_b_addr);
        default: ev = 0;
      endcase
      evonly = (md == 4'd3) || (md == 4'd4);
      beg    = m_cfg[6] || evonly;
      e_trig = 0; e_store = 0; fin = 0;
      if (arm0) begin
        if (evonly) begin
          e_trig = ev; e_store = ev;
        end else if (beg) begin
          e_trig = ev && !m_started; e_store = acc && (m_started || ev);
        end else begin
          e_trig = ev; e_store = acc;
        end
        if (beg && e_store && m_cnt == DEPTH - 1) fin = 1;
        if (!beg && ev) fin = 1;
        if (beg && e_store) m_cnt++;
        if (beg && ev) m_started = 1;
        if (qa) m_aseen = 1;
        if (e_store) begin e_saddr = bus_addr; e_sdata = bus_data; end
      end else begin
        m_aseen = 0;
      end
      if (!arm0 || !tagm) begin
        m_pa = 0; m_pb = 0;
      end else if (bus_fetch && (bus_addr == cmp_a_addr || bus_addr == cmp_b_addr)) begin
        m_pa = (bus_addr == cmp_a_addr); m_pb = (bus_addr == cmp_b_addr);
      end else if (core_exec || core_flush) begin
        m_pa = 0; m_pb = 0;
      end
      if (fin) begin m_armed = 0; m_done = 1; end
      if (cfg_wr_en && !arm0) m_cfg = cfg_wr_data & 8'hCF;
      if (arm_wr_en) begin
        m_armed = arm_wr_val; m_aseen = 0;
        if (arm_wr_val) begin m_done = 0; m_cnt = 0; m_started = 0; end
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (trig_pulse !== e_trig || store_en !== e_store || capture_done !== m_done ||
          armed !== m_armed || cfg_rd_data !== m_cfg ||
          (e_store && (store_addr !== e_saddr || store_data !== e_sdata))) begin
        n_fail++;
        $display("FAIL %s cycle: trig=%0b store=%0b done=%0b armed=%0b cfg=%02h sa=%04h sd=%02h expected trig=%0b store=%0b done=%0b armed=%0b cfg=%02h sa=%04h sd=%02h",
                 cur_req, trig_pulse, store_en, capture_done, armed, cfg_rd_data, store_addr, store_data,
                 e_trig, e_store, m_done, m_armed, m_cfg, e_saddr, e_sdata);
      end
      if (trig_pulse) n_trig++;
      if (store_en)   n_store++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rd, input logic wr, input logic fe, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic ex, input logic fl);
    bus_rd = rd; bus_wr = wr; bus_fetch = fe; bus_addr = a; bus_data = d;
    core_exec = ex; core_flush = fl;
    @(negedge clk); #1;
    bus_rd = 0; bus_wr = 0; bus_fetch = 0; core_exec = 0; core_flush = 0;
    cfg_wr_en = 0; arm_wr_en = 0;
  endtask

  task automatic rd_at(input logic [AW-1:0] a);  cyc(1, 0, 0, a, 8'h00, 0, 0); endtask
  task automatic wr_at(input logic [AW-1:0] a, input logic [DW-1:0] d); cyc(0, 1, 0, a, d, 0, 0); endtask
  task automatic idle();                          cyc(0, 0, 0, '0, '0, 0, 0); endtask
  task automatic wcfg(input logic [7:0] v);       cfg_wr_en = 1; cfg_wr_data = v; idle(); endtask
  task automatic warm(input logic v);             arm_wr_en = 1; arm_wr_val = v; idle(); endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin : main
    int t0, s0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    cur_req = "R1";
    idle();
    chk("R1 reset cfg", cfg_rd_data, 0);
    chk("R12 reset armed", armed, 0);
    chk("R12 reset done", capture_done, 0);
    wcfg(8'hFF);
    chk("R1 readback mask", cfg_rd_data, 8'hCF);

    // undefined mode, writes while armed ignored
    cur_req = "R7";
    warm(1);
    t0 = n_trig; s0 = n_store;
    rd_at(16'h0010); rd_at(16'h0040); wr_at(16'h0010, 8'h11);
    chk("R7 no trigger", n_trig - t0, 0);
    chk("R7 no store", n_store - s0, 0);
    cur_req = "R2";
    wcfg(8'h00);
    chk("R2 write ignored", cfg_rd_data, 8'hCF);
    warm(0);

    // mode 0, end trace
    cur_req = "R10";
    wcfg(8'h00); warm(1);
    t0 = n_trig; s0 = n_store;
    rd_at(16'h0020); wr_at(16'h0021, 8'h5A);
    chk("R3 no early trigger", n_trig - t0, 0);
    rd_at(16'h0010);
    chk("R3 trigger on A", n_trig - t0, 1);
    chk("R10 stores incl trigger", n_store - s0, 3);
    chk("R10 done", capture_done, 1);
    chk("R10 disarmed", armed, 0);
    rd_at(16'h0022);
    chk("R12 no store when disarmed", n_store - s0, 3);

    // mode 1, begin trace
    cur_req = "R9";
    wcfg(8'h41); warm(1);
    chk("R12 arm clears done", capture_done, 0);
    t0 = n_trig; s0 = n_store;
    rd_at(16'h0030);
    chk("R9 nothing before trigger", n_store - s0, 0);
    wr_at(16'h0040, 8'h77);
    chk("R3 trigger on B", n_trig - t0, 1);
    for (int i = 0; i < DEPTH - 1; i++) rd_at(16'h0050 + 16'(i));
    chk("R9 depth stores", n_store - s0, DEPTH);
    chk("R9 single trigger", n_trig - t0, 1);
    chk("R9 done", capture_done, 1);
    rd_at(16'h0060);
    chk("R9 stop after depth", n_store - s0, DEPTH);

    // A then B
    cur_req = "R4";
    wcfg(8'h02); warm(1);
    t0 = n_trig;
    wr_at(16'h0040, 8'h01);
    chk("R4 B alone no trigger", n_trig - t0, 0);
    rd_at(16'h0010); idle(); rd_at(16'h0040);
    chk("R4 B after A", n_trig - t0, 1);
    warm(1); rd_at(16'h0010); warm(0); warm(1);
    t0 = n_trig;
    rd_at(16'h0040);
    chk("R4 disarm clears A", n_trig - t0, 0);
    warm(0);

    // data modes
    cur_req = "R5";
    cmp_b_addr = 16'h00A5;
    wcfg(8'h05); warm(1);
    t0 = n_trig;
    wr_at(16'h0010, 8'h11);
    chk("R5 eq mismatch", n_trig - t0, 0);
    wr_at(16'h0010, 8'hA5);
    chk("R5 eq match", n_trig - t0, 1);
    wcfg(8'h06); warm(1);
    t0 = n_trig;
    wr_at(16'h0010, 8'hA5);
    chk("R5 ne equal data", n_trig - t0, 0);
    wr_at(16'h0010, 8'h3C);
    chk("R5 ne differing data", n_trig - t0, 1);

    // range modes
    cur_req = "R6";
    cmp_a_addr = 16'h0020; cmp_b_addr = 16'h0028;
    wcfg(8'h07); warm(1);
    t0 = n_trig;
    rd_at(16'h001F); rd_at(16'h0029);
    chk("R6 outside of inside-range", n_trig - t0, 0);
    rd_at(16'h0028);
    chk("R6 upper bound inclusive", n_trig - t0, 1);
    warm(1);
    rd_at(16'h0020);
    chk("R6 lower bound inclusive", n_trig - t0, 2);
    wcfg(8'h08); warm(1);
    t0 = n_trig;
    rd_at(16'h0020); rd_at(16'h0028); rd_at(16'h0024);
    chk("R6 in range no outside trigger", n_trig - t0, 0);
    rd_at(16'h0029);
    chk("R6 above B", n_trig - t0, 1);

    // tag qualification
    cur_req = "R8";
    cmp_a_addr = 16'h0010; cmp_b_addr = 16'h0040;
    wcfg(8'h80); warm(1);
    t0 = n_trig;
    rd_at(16'h0010);
    cyc(0, 0, 1, 16'h0010, 8'h00, 0, 0);
    cyc(0, 0, 0, 16'h0000, 8'h00, 0, 1);
    cyc(0, 0, 0, 16'h0000, 8'h00, 1, 0);
    chk("R8 read or flushed fetch no trigger", n_trig - t0, 0);
    cyc(0, 0, 1, 16'h0010, 8'h00, 0, 0);
    idle();
    chk("R8 waits for exec", n_trig - t0, 0);
    cyc(0, 0, 0, 16'h0000, 8'h00, 1, 0);
    chk("R8 exec fires", n_trig - t0, 1);
    chk("R8 end trace done", capture_done, 1);
    cmp_b_addr = 16'h00A5;
    wcfg(8'h85); warm(1);
    t0 = n_trig;
    wr_at(16'h0010, 8'hA5);
    chk("R8 tag ignored in data mode", n_trig - t0, 1);

    // event-only modes
    cur_req = "R11";
    cmp_b_addr = 16'h0040;
    wcfg(8'h03); warm(1);
    s0 = n_store; t0 = n_trig;
    rd_at(16'h0010); rd_at(16'h0022);
    chk("R11 no store off B", n_store - s0, 0);
    for (int i = 0; i < DEPTH; i++) wr_at(16'h0040, 8'(8'h30 + i));
    chk("R11 one store per B", n_store - s0, DEPTH);
    chk("R11 one trigger per B", n_trig - t0, DEPTH);
    chk("R11 done after depth", capture_done, 1);
    cur_req = "R12";
    idle(); idle(); idle();
    chk("R12 done persists", capture_done, 1);
    cur_req = "R11";
    wcfg(8'h04); warm(1);
    chk("R12 arm clears done", capture_done, 0);
    s0 = n_store;
    wr_at(16'h0040, 8'h01);
    chk("R11 B before A ignored", n_store - s0, 0);
    rd_at(16'h0010); wr_at(16'h0040, 8'h02); wr_at(16'h0040, 8'h03);
    chk("R11 stores after A", n_store - s0, 2);
    warm(0);
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule